// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator

This block turns the empty state of a UART transmit FIFO into the "transmitter holding register empty" interrupt request and its identification code. The FIFO storage, the shift register and the serial line are outside the block. It watches the FIFO empty flag, the FIFO write strobe, the occupancy level and a once-per-bit baud tick. From these it derives a transmit-empty indication. A separate latch turns that indication into a request that software clears by writing the FIFO or by reading the interrupt identification register.

The block paces the empty indication. If the FIFO never held two or more characters at once since the indication last rose, the indication waits for `frame_bits - 1` baud ticks before it rises. That wait is one character time without its final stop bit. If two or more characters were queued together, the indication rises at once. When the FIFO mode bit changes while the block is enabled and the FIFO is already empty, the request is raised at once.

Top module: `txe_irq_gen`

## Requirements
- R1: While and just after reset, `tx_empty` is 1, `tx_irq` is 0 and `irq_id` is 4'h1.
- R2: `tx_irq` is 1 only while both `fcr_fifo_en` and `ier_tx_en` are 1. A `tx_empty` rise while either enable is 0 leaves no pending request behind.
- R3: A cycle with `fifo_wr` = 1 makes `tx_empty` and `tx_irq` 0 on the next clock edge.
- R4: A cycle with `iir_rd` = 1 makes `tx_irq` 0 on the next clock edge and leaves `tx_empty` unchanged.
- R5: If `fifo_level` was 2 or more in any cycle since `tx_empty` last rose, then `tx_empty` rises on the first edge that samples `fifo_empty` = 1 with no write. `tx_irq` rises on the same edge when both enables are 1.
- R6: Otherwise the first such edge starts a wait. `tx_empty` rises on the edge that samples the (`frame_bits` - 1)-th `baud_tick` while the FIFO stays empty, and `tx_irq` rises on that edge too.
- R7: A write, or `fifo_empty` = 0, during the wait abandons it. `tx_empty` stays 0, and the next empty period restarts the full wait.
- R8: A one-cycle `fcr_en_chg` pulse while both enables are 1 and `tx_empty` is 1 sets `tx_irq` on the next edge. Turning `fcr_fifo_en` on without the pulse raises nothing.
- R9: `irq_id` is 4'h2 while `tx_irq` is 1 and 4'h1 (nothing pending) otherwise.
- R10: The two-or-more record is cleared when `tx_empty` rises, so a later single-character period waits again.
- R11: A `frame_bits` value of 0 or 1 gives a zero-length wait, so `tx_empty` rises as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | Transmit FIFO holds no character |
| fifo_wr | input | 1 | One-cycle write strobe into the transmit FIFO |
| iir_rd | input | 1 | One-cycle read strobe of the interrupt identification register |
| fcr_fifo_en | input | 1 | FIFO mode enable |
| fcr_en_chg | input | 1 | One-cycle pulse when the FIFO mode enable changes |
| ier_tx_en | input | 1 | Transmit interrupt enable |
| fifo_level | input | LVL_W (5) | Current FIFO occupancy |
| baud_tick | input | 1 | One pulse per serial bit time |
| frame_bits | input | FB_W (4) | Bits per serial frame, start and stop included |
| tx_empty | output | 1 | Paced transmit-empty indication |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| irq_id | output | 4 | Interrupt identification code contribution |

## Verification
The bench uses the defaults: a depth of 16, a two-character threshold and a 4-bit frame length. With these it can fill the FIFO to its full depth, and it can try frame lengths from the zero-wait case up to 12 bits. The vector table alternates single-character and multi-character fills. This shows both the immediate path and the paced path, and it shows the threshold record being cleared between fills. Directed cases cover a cancelled wait, a write clearing a pending request, disabled enables and the FIFO-mode change pulse.

// File: rtl/txe_pkg.sv
`timescale 1ns/1ps
// Package: shared identification codes for the transmit-empty interrupt.
// Assumes a 4-bit identification field in which bit 0 = 1 means "nothing pending".
package txe_pkg;
    typedef logic [3:0] irq_id_t;
    localparam irq_id_t ID_NONE = 4'h1;
    localparam irq_id_t ID_TXE  = 4'h2;
endpackage

// File: rtl/txe_fill_track.sv
`timescale 1ns/1ps
// Module: records whether the FIFO held MULTI_LEVEL or more characters at once
// since the paced empty indication last rose.
// Assumes fifo_level is the occupancy seen in the current cycle.
module txe_fill_track #(
    parameter int LVL_W       = 5,
    parameter int MULTI_LEVEL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             empty_set,
    output logic             multi
);
    localparam logic [LVL_W-1:0] THRESH = LVL_W'(MULTI_LEVEL);

    logic multi_q;

    // Sticky set at or above the threshold, cleared when the indication rises.
    always_ff @(posedge clk) begin
        if (!rst_n)                    multi_q <= 1'b0;
        else if (fifo_level >= THRESH) multi_q <= 1'b1;
        else if (empty_set)            multi_q <= 1'b0;
    end

    assign multi = multi_q;
endmodule

// File: rtl/txe_empty_timer.sv
`timescale 1ns/1ps
// Module: produces the paced transmit-empty indication.
// It rises at once when a multi-character fill was seen. Otherwise it rises
// after frame_bits-1 baud ticks. Assumes baud_tick pulses once per bit time
// and frame_bits stays constant during a wait.
module txe_empty_timer #(
    parameter int FB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_empty,
    input  logic            fifo_wr,
    input  logic            multi,
    input  logic            baud_tick,
    input  logic [FB_W-1:0] frame_bits,
    output logic            tx_empty,
    output logic            empty_set
);
    logic            empty_q;
    logic            wait_q;
    logic [FB_W-1:0] rem_q;
    logic [FB_W-1:0] delay_load;
    logic            start;

    // Wait length: one frame minus its last stop bit, floored at zero.
    assign delay_load = (frame_bits == '0) ? '0 : frame_bits - 1'b1;

    // Decide whether the indication rises now or a wait begins.
    always_comb begin
        empty_set = 1'b0;
        start     = 1'b0;
        if (!empty_q && fifo_empty && !fifo_wr) begin
            if (!wait_q) begin
                if (multi || delay_load == '0) empty_set = 1'b1;
                else                           start     = 1'b1;
            end else if (baud_tick && rem_q == FB_W'(1)) begin
                empty_set = 1'b1;
            end
        end
    end

    // Indication, wait flag and remaining tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            wait_q  <= 1'b0;
            rem_q   <= '0;
        end else if (fifo_wr || !fifo_empty) begin
            empty_q <= 1'b0;
            wait_q  <= 1'b0;
        end else if (empty_set) begin
            empty_q <= 1'b1;
            wait_q  <= 1'b0;
        end else if (start) begin
            wait_q  <= 1'b1;
            rem_q   <= delay_load;
        end else if (wait_q && baud_tick) begin
            rem_q   <= rem_q - 1'b1;
        end
    end

    assign tx_empty = empty_q;
endmodule

// File: rtl/txe_irq_latch.sv
`timescale 1ns/1ps
// Module: holds the pending transmit-empty request.
// It sets when the indication rises, or on a FIFO-mode change while empty.
// It clears on a write, an identification read or a disarm; a clear wins
// over a set in the same cycle.
module txe_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic empty_set,
    input  logic tx_empty,
    input  logic fcr_en_chg,
    input  logic fifo_wr,
    input  logic iir_rd,
    output logic pending
);
    logic pend_q;

    // Pending-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pend_q <= 1'b0;
        else if (!armed || fifo_wr || iir_rd)   pend_q <= 1'b0;
        else if (empty_set || (fcr_en_chg && tx_empty)) pend_q <= 1'b1;
    end

    assign pending = pend_q;
endmodule

// File: rtl/txe_irq_gen.sv
`timescale 1ns/1ps
// Module: top of the transmit-empty interrupt generator.
// Combines the fill record, the paced empty timer and the request latch, and
// drives the identification code. Assumes all inputs are synchronous to clk.
module txe_irq_gen
    import txe_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int MULTI_LEVEL = 2,
    parameter int FB_W        = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  logic             fifo_wr,
    input  logic             iir_rd,
    input  logic             fcr_fifo_en,
    input  logic             fcr_en_chg,
    input  logic             ier_tx_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             baud_tick,
    input  logic [FB_W-1:0]  frame_bits,
    output logic             tx_empty,
    output logic             tx_irq,
    output logic [3:0]       irq_id
);
    logic armed;
    logic multi;
    logic empty_set;
    logic pending;

    // Request path is live only with FIFO mode and the interrupt enabled.
    assign armed = fcr_fifo_en & ier_tx_en;

    txe_fill_track #(.LVL_W(LVL_W), .MULTI_LEVEL(MULTI_LEVEL)) u_fill (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
        .empty_set(empty_set), .multi(multi)
    );

    txe_empty_timer #(.FB_W(FB_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
        .multi(multi), .baud_tick(baud_tick), .frame_bits(frame_bits),
        .tx_empty(tx_empty), .empty_set(empty_set)
    );

    txe_irq_latch u_latch (
        .clk(clk), .rst_n(rst_n), .armed(armed), .empty_set(empty_set),
        .tx_empty(tx_empty), .fcr_en_chg(fcr_en_chg), .fifo_wr(fifo_wr),
        .iir_rd(iir_rd), .pending(pending)
    );

    // Output request and identification code.
    assign tx_irq = pending & armed;
    assign irq_id = tx_irq ? ID_TXE : ID_NONE;
endmodule

// File: rtl/txe_irq_gen_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for txe_irq_gen, attached by bind.
module txe_irq_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_empty,
    input logic       fifo_wr,
    input logic       iir_rd,
    input logic       tx_empty,
    input logic       tx_irq,
    input logic [3:0] irq_id
);
    p_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> (!tx_empty && !tx_irq));

    p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> !tx_irq);

    p_rd_keeps_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && !fifo_wr && fifo_empty && tx_empty) |=> tx_empty);

    p_irq_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> tx_empty);

    p_rise_needs_fifo_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(fifo_empty));

    p_full_blocks_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |=> !tx_empty);

    p_id_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id == 4'h1) || (irq_id == 4'h2));
endmodule

bind txe_irq_gen txe_irq_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
    .iir_rd(iir_rd), .tx_empty(tx_empty), .tx_irq(tx_irq), .irq_id(irq_id)
);

// File: tb/txe_irq_gen_tb_top.sv
`timescale 1ns/1ps
module txe_irq_gen_tb_top;
    localparam int LVL_W = 5;
    localparam int FB_W  = 4;
    localparam int NVEC  = 6;
    // Scenario table: frame length and peak fill per row.
    localparam int VEC_FB  [NVEC] = '{10, 10, 7, 12, 8, 1};
    localparam int VEC_LVL [NVEC] = '{1,  2,  1, 16, 1, 1};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fifo_empty, fifo_wr, iir_rd;
    logic             fcr_fifo_en, fcr_en_chg, ier_tx_en, baud_tick;
    logic [LVL_W-1:0] fifo_level;
    logic [FB_W-1:0]  frame_bits;
    logic             tx_empty, tx_irq;
    logic [3:0]       irq_id;
    int               n_chk = 0;
    int               n_bad = 0;

    always #2.5 clk = ~clk;

    txe_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
        .iir_rd(iir_rd), .fcr_fifo_en(fcr_fifo_en), .fcr_en_chg(fcr_en_chg),
        .ier_tx_en(ier_tx_en), .fifo_level(fifo_level), .baud_tick(baud_tick),
        .frame_bits(frame_bits), .tx_empty(tx_empty), .tx_irq(tx_irq),
        .irq_id(irq_id)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int lvl);
        for (int k = 1; k <= lvl; k++) begin
            fifo_wr = 1'b1; fifo_empty = 1'b0; fifo_level = LVL_W'(k);
            step();
            fifo_wr = 1'b0;
        end
        for (int k = lvl - 1; k >= 1; k--) begin
            fifo_level = LVL_W'(k);
            step();
        end
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            baud_tick = 1'b1; step(); baud_tick = 1'b0; step();
        end
    endtask

    // Empty the FIFO and count baud ticks until the indication rises.
    task automatic measure(output int n);
        n = 0;
        fifo_level = '0; fifo_empty = 1'b1;
        step();
        while (!tx_empty && n < 20) begin
            baud_tick = 1'b1; step(); baud_tick = 1'b0;
            n++;
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ticks;
        int exp_t;
        rst_n = 1'b0; fifo_empty = 1'b1; fifo_wr = 1'b0; iir_rd = 1'b0;
        fcr_fifo_en = 1'b1; fcr_en_chg = 1'b0; ier_tx_en = 1'b1;
        baud_tick = 1'b0; fifo_level = '0; frame_bits = 4'd10;
        step(); step();
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 tx_irq",   int'(tx_irq),   0);
        chk("R1 irq_id",   int'(irq_id),   1);
        rst_n = 1'b1;
        step();
        chk("R1 after release irq", int'(tx_irq), 0);

        // Table walk: R5, R6, R10, R11, R9, R4.
        for (int i = 0; i < NVEC; i++) begin
            frame_bits = FB_W'(VEC_FB[i]);
            fill(VEC_LVL[i]);
            chk("R3 written not empty", int'(tx_empty), 0);
            measure(ticks);
            exp_t = (VEC_LVL[i] >= 2 || VEC_FB[i] <= 1) ? 0 : VEC_FB[i] - 1;
            chk("R5/R6/R10/R11 tick count", ticks, exp_t);
            chk("R9 irq raised", int'(tx_irq), 1);
            chk("R9 id code", int'(irq_id), 2);
            iir_rd = 1'b1; step(); iir_rd = 1'b0;
            chk("R4 read clears irq", int'(tx_irq), 0);
            chk("R4 read keeps empty", int'(tx_empty), 1);
            chk("R9 id none", int'(irq_id), 1);
        end

        // R7: cancel a wait by writing, then check a full restart.
        frame_bits = 4'd10;
        fill(1);
        fifo_level = '0; fifo_empty = 1'b1; step();
        tick_n(3);
        chk("R7 still waiting", int'(tx_empty), 0);
        fifo_wr = 1'b1; fifo_empty = 1'b0; fifo_level = 5'd1; step(); fifo_wr = 1'b0;
        tick_n(10);
        chk("R7 cancelled stays low", int'(tx_empty), 0);
        chk("R7 no irq", int'(tx_irq), 0);
        measure(ticks);
        chk("R7 full restart", ticks, 9);

        // R3: write clears a pending request.
        chk("R3 irq pending before write", int'(tx_irq), 1);
        fifo_wr = 1'b1; fifo_empty = 1'b0; fifo_level = 5'd1; step(); fifo_wr = 1'b0;
        chk("R3 write clears irq", int'(tx_irq), 0);
        chk("R3 write clears empty", int'(tx_empty), 0);

        // R2: interrupt disabled, indication still rises.
        ier_tx_en = 1'b0;
        measure(ticks);
        chk("R2 empty rises", int'(tx_empty), 1);
        chk("R2 no irq when disabled", int'(tx_irq), 0);
        ier_tx_en = 1'b1; step();
        chk("R2 enabling leaves nothing pending", int'(tx_irq), 0);

        // R8: mode change pulse raises the request at once.
        fcr_fifo_en = 1'b0; step();
        fcr_fifo_en = 1'b1; step();
        chk("R8 no pulse no irq", int'(tx_irq), 0);
        fcr_fifo_en = 1'b0; step();
        fcr_fifo_en = 1'b1; fcr_en_chg = 1'b1; step(); fcr_en_chg = 1'b0;
        chk("R8 pulse raises irq", int'(tx_irq), 1);
        chk("R9 id after pulse", int'(irq_id), 2);
        ier_tx_en = 1'b0; #1;
        chk("R2 drop enable masks irq", int'(tx_irq), 0);
        ier_tx_en = 1'b1;
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule